// File: doc/BRIEF.md
# Period-Measuring Times-Eight Frequency Multiplier

This block turns a slow, asynchronous square wave into a tone at eight times its rate, using only counters running on a fast system clock. It synchronizes the input and detects rising edges. It counts clocks from one edge to the next. It smooths that count with a first-order recursive filter. From the smoothed period it derives an output half-period by dropping four bits, and a reloading down-counter flips the tone each time a half-period has elapsed.

A lock flag tells the consumer when the tone can be trusted. The flag rises only after two input rising edges have given a complete period. It falls when no edge arrives before the period counter saturates. While the flag is low, the tone is held low.

Top module: `pmul_x8`

## Requirements
- R1: While reset is active, and for the first cycles after its release, `tone_o` and `valid_o` are both 0.
- R2: `sig_in` passes through two synchronizing flops before edge detection. When `sig_in` rises for the second time after lock was lost, `valid_o` reads 1 after the third rising clock edge and still reads 0 after the second.
- R3: `valid_o` rises only on a detected rising edge, and one rising edge alone never sets it.
- R4: The measured period is the number of clocks between two consecutive detected rising edges. The counter restarts at 1 on each edge. The first complete measurement is loaded into the filter unchanged.
- R5: Each later measurement m updates the filtered period f as f + ((m - f) arithmetically shifted right by 3).
- R6: The output half-period is f shifted right by 4; the four lowest bits of f are discarded.
- R7: While locked, each high run and each low run of `tone_o` lasts exactly as many clocks as the half-period. A half-period of 0 counts as 1. The tone never changes while the down-counter is nonzero.
- R8: The down-counter reloads from the current half-period at every toggle, so a new filtered period takes effect at the next toggle.
- R9: If the period counter reaches its maximum (2^CNT_W - 1) with no edge, it holds there. `valid_o` then drops, and two new rising edges are needed to lock again.
- R10: Whenever `valid_o` is 0, `tone_o` is 0 from the following clock on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sig_in | input | 1 | Slow asynchronous input square wave |
| tone_o | output | 1 | Output square wave at eight times the input rate |
| valid_o | output | 1 | High while a valid filtered period is held |

## Verification
The bench measures run lengths of the tone for input periods that divide evenly by 16, for one that does not (the discarded low bits must not round up), and for very short periods, where a half-period of zero must still give runs of one clock. A design without the minus-one reload would produce runs one clock too long. A filter that is not seeded from the first measurement would start far too fast. After a step from 320 to 640 clocks, the first filtered run must be 22 clocks; a wrong shift or a sign error gives a different value. The bench also stops the input until the counter saturates, then checks that lock is lost, that the tone is held low, and that a single new edge does not restore lock. A design that kept its old state would keep toggling instead.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic [1:0] {
    LK_IDLE   = 2'd0,
    LK_ARMED  = 2'd1,
    LK_LOCKED = 2'd2
  } lock_st_e;
endpackage

// File: rtl/pmul_edge_det.sv
module pmul_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb sync_d[0] = sig_in;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_chain
      always_comb sync_d[i] = sync_q[i-1];
    end
  endgenerate

  always_comb begin
    prev_d = sync_q[STAGES-1];
    rise   = sync_q[STAGES-1] & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/pmul_period_est.sv
module pmul_period_est
  import pmul_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int FILT_SH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic [CNT_W-1:0] per_cnt,
  output logic [CNT_W-1:0] filt,
  output logic             valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  lock_st_e           st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   filt_q, filt_d;
  logic               cnt_sat;
  logic signed [CNT_W:0] diff, step, sum;

  always_comb begin
    cnt_sat = (cnt_q == CNT_MAX);
    diff    = $signed({1'b0, cnt_q}) - $signed({1'b0, filt_q});
    step    = diff >>> FILT_SH;
    sum     = $signed({1'b0, filt_q}) + step;
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    filt_d = filt_q;
    if (rise) begin
      cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
      if (cnt_sat) begin
        st_d = LK_ARMED;
      end else begin
        case (st_q)
          LK_IDLE:  st_d = LK_ARMED;
          LK_ARMED: begin
            st_d   = LK_LOCKED;
            filt_d = cnt_q;
          end
          LK_LOCKED: filt_d = sum[CNT_W-1:0];
          default:  st_d = LK_IDLE;
        endcase
      end
    end else if (cnt_sat) begin
      st_d = LK_IDLE;
    end else begin
      cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_IDLE;
      cnt_q  <= '0;
      filt_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  always_comb begin
    per_cnt = cnt_q;
    filt    = filt_q;
    valid   = (st_q == LK_LOCKED);
  end
endmodule

// File: rtl/pmul_tone.sv
module pmul_tone #(
  parameter int CNT_W   = 16,
  parameter int HALF_SH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [CNT_W-1:0] filt,
  output logic             tone,
  output logic [CNT_W-1:0] dcnt
);
  logic [CNT_W-1:0] half, load;
  logic [CNT_W-1:0] dcnt_q, dcnt_d;
  logic             tone_q, tone_d;
  logic             toggle_en;

  always_comb begin
    half      = filt >> HALF_SH;
    load      = (half == '0) ? '0 : half - CNT_W'(1);
    toggle_en = valid && (dcnt_q == '0);
  end

  always_comb begin
    tone_d = tone_q;
    dcnt_d = dcnt_q;
    if (!valid) begin
      tone_d = 1'b0;
      dcnt_d = '0;
    end else if (toggle_en) begin
      tone_d = ~tone_q;
      dcnt_d = load;
    end else begin
      dcnt_d = dcnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone_q <= 1'b0;
      dcnt_q <= '0;
    end else begin
      tone_q <= tone_d;
      dcnt_q <= dcnt_d;
    end
  end

  always_comb begin
    tone = tone_q;
    dcnt = dcnt_q;
  end
endmodule

// File: rtl/pmul_x8.sv
module pmul_x8 #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_SH     = 3,
  parameter int RATIO_LOG2  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic tone_o,
  output logic valid_o
);
  localparam int HALF_SH = RATIO_LOG2 + 1;

  logic [1:0]       rst_pipe;
  logic             rst_sn;
  logic             rise;
  logic [CNT_W-1:0] per_cnt, filt, dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  always_comb rst_sn = rst_pipe[1];

  pmul_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_sn), .sig_in(sig_in), .rise(rise)
  );

  pmul_period_est #(.CNT_W(CNT_W), .FILT_SH(FILT_SH)) u_est (
    .clk(clk), .rst_n(rst_sn), .rise(rise),
    .per_cnt(per_cnt), .filt(filt), .valid(valid_o)
  );

  pmul_tone #(.CNT_W(CNT_W), .HALF_SH(HALF_SH)) u_tone (
    .clk(clk), .rst_n(rst_sn), .valid(valid_o), .filt(filt),
    .tone(tone_o), .dcnt(dcnt)
  );
endmodule

// File: rtl/pmul_x8_chk.sv
module pmul_x8_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             rise,
  input logic [CNT_W-1:0] per_cnt,
  input logic [CNT_W-1:0] dcnt,
  input logic             valid_o,
  input logic             tone_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_low_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    !valid_o |=> !tone_o);

  p_lock_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(valid_o) |-> $past(rise));

  p_hold_between_toggles_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (valid_o && dcnt != '0) |=> $stable(tone_o));

  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (per_cnt == CNT_MAX && !rise) |=> per_cnt == CNT_MAX);

  p_edge_restart_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    rise |=> per_cnt == CNT_W'(1));
endmodule

bind pmul_x8 pmul_x8_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .rise(rise), .per_cnt(per_cnt),
  .dcnt(dcnt), .valid_o(valid_o), .tone_o(tone_o)
);

// File: tb/sim_pmul_x8.sv
module sim_pmul_x8;
  logic clk, rst_n, sig_in;
  logic tone_o, valid_o;
  int checks = 0, fails = 0;
  bit done = 0;

  pmul_x8 #(.CNT_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .tone_o(tone_o), .valid_o(valid_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    sig_in = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic drive(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      sig_in = 1;
      repeat (p / 2) @(negedge clk);
      sig_in = 0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic meas_run(output int len);
    logic v;
    int guard;
    v = tone_o; guard = 0;
    while (tone_o == v && guard < 5000) begin @(negedge clk); guard++; end
    v = tone_o; len = 0;
    do begin @(negedge clk); len++; end while (tone_o == v && len < 5000);
  endtask

  task automatic t_reset();
    sig_in = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    chk(tone_o == 0 && valid_o == 0, "R1 in reset", {tone_o, valid_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(tone_o == 0 && valid_o == 0, "R1 after release", {tone_o, valid_o}, 0);
  endtask

  task automatic t_lock_latency();
    int len;
    sig_in = 1; repeat (160) @(negedge clk);
    sig_in = 0; repeat (60) @(negedge clk);
    chk(valid_o == 0, "R3 one edge only", valid_o, 0);
    repeat (100) @(negedge clk);
    sig_in = 1;
    repeat (2) @(negedge clk);
    chk(valid_o == 0, "R2 two clocks after edge", valid_o, 0);
    @(negedge clk);
    chk(valid_o == 1, "R2 three clocks after edge", valid_o, 1);
    repeat (157) @(negedge clk);
    sig_in = 0; repeat (160) @(negedge clk);
    fork
      drive(320, 2);
      begin repeat (30) @(negedge clk); meas_run(len);
        chk(len == 20, "R4 seeded run P=320", len, 20); end
    join
  endtask

  task automatic t_ratio(input int p, input int exp, input string tag);
    int len;
    do_reset();
    fork
      drive(p, 5);
      begin repeat (2 * p + p / 4 + 4) @(negedge clk); meas_run(len);
        chk(len == exp, tag, len, exp); end
    join
  endtask

  task automatic t_filter_step();
    int len;
    do_reset();
    drive(320, 3);
    fork
      drive(640, 3);
      begin repeat (740) @(negedge clk); meas_run(len);
        chk(len == 22, "R5 R8 step 320->640", len, 22); end
    join
  endtask

  task automatic t_timeout();
    do_reset();
    drive(320, 4);
    chk(valid_o == 1, "R9 locked before gap", valid_o, 1);
    repeat (4200) @(negedge clk);
    chk(valid_o == 0, "R9 lock lost on saturation", valid_o, 0);
    chk(tone_o == 0, "R10 tone low when unlocked", tone_o, 0);
    drive(320, 1);
    repeat (100) @(negedge clk);
    chk(valid_o == 0, "R9 one edge after gap", valid_o, 0);
    chk(tone_o == 0, "R10 tone still low", tone_o, 0);
    drive(320, 2);
    chk(valid_o == 1, "R9 relock after two edges", valid_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    sig_in = 0; rst_n = 0;
    @(negedge clk);
    t_reset();
    t_lock_latency();
    t_ratio(480, 30, "R6 R7 P=480");
    t_ratio(328, 20, "R6 low bits dropped P=328");
    t_ratio(40, 2, "R7 P=40");
    t_ratio(8, 1, "R7 zero half-period P=8");
    t_filter_step();
    t_timeout();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule